// File: doc/BRIEF.md
# Nonvolatile Preset Store Sequencer

This block owns a small array of nonvolatile words. The first words back the volatile wiper registers of a multi-channel digital resistor. The remaining words are spare storage that the user can address. A command decoder outside the block hands it one request at a time. The block stores a word, recalls one wiper or all of them, or reads back a stored word or a live wiper value. It reports through an active-high ready output when it has finished, and the time ready stays low depends on the kind of operation.

The array is a register file. The write time of real nonvolatile memory is modelled by a busy counter, and the length of each busy window is a parameter given in clock cycles. At power-up, every wiper is reloaded from its stored word before any command is taken. An active-low preset pin does the same reload at run time. A word that has never been written reads back as midscale. A write-protect input, active low, blocks every change to the array. Wiper arithmetic and serial shifting belong to neighbouring blocks.

Top module: `nv_preset_seq`

## Requirements
- R1: After reset is released, ready_o stays low for exactly T_RECALL cycles. When it rises, wiper_we_o pulses with every bit set and each lane carries its stored word.
- R2: A word never written since reset reads back as midscale, which is 2^(W-1) (512 for W=10).
- R3: Op code 2 (save) at a wiper address copies that wiper's current value (wiper 0 at address 0, wiper 1 at address 1) into the word, and holds ready_o low for exactly T_STORE cycles. At an address with no wiper, op code 2 does nothing and ready_o stays high.
- R4: Op code 3 (direct write) stores cmd_data at any address, with ready_o low for exactly T_STORE cycles.
- R5: While wp_n is low, op codes 2 and 3 leave every word unchanged, and ready_o stays high.
- R6: Op code 8 holds ready_o low for exactly T_RECALL cycles. It then pulses every bit of wiper_we_o, and each lane carries its own stored word.
- R7: Op code 9 holds ready_o low for exactly T_READ cycles. It then pulses rd_valid_o, with rd_data_o equal to the stored word at cmd_addr.
- R8: Op code 10 at a wiper address holds ready_o low for exactly T_READ cycles. It then returns on rd_data_o the value that wiper had when the command was accepted.
- R9: Op code 1 at a wiper address pulses only that lane's wiper_we_o bit, with the stored word, in the cycle after acceptance. ready_o stays high.
- R10: A falling edge on preset_n, seen after SYNC_STAGES synchronising flops, starts the same all-wiper recall as op code 8. A falling edge that arrives while ready_o is low is held, and the recall runs as soon as the current operation ends.
- R11: A request presented while ready_o is low is ignored: drop_o pulses in the next cycle and the array is not changed.
- R12: Op codes 0, 4 to 7 and 11 to 15 have no effect: ready_o stays high and no wiper_we_o or rd_valid_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| cmd_valid | input | 1 | Request strobe, sampled when ready_o is high |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | AW | Word address (wipers first, then spare words) |
| cmd_data | input | W | Data for a direct write |
| wiper_cur_i | input | NUM_WIPER*W | Present wiper values, lane i at bits i*W upward |
| preset_n | input | 1 | Asynchronous preset pin, falling edge triggers a recall |
| wp_n | input | 1 | Write protect, active low |
| ready_o | output | 1 | High when idle, low while an operation is in progress |
| drop_o | output | 1 | One-cycle pulse marking a request that was ignored |
| wiper_we_o | output | NUM_WIPER | Wiper load strobes, one per lane |
| wiper_data_o | output | NUM_WIPER*W | Wiper load values, lane i at bits i*W upward |
| rd_valid_o | output | 1 | One-cycle pulse when a readback completes |
| rd_data_o | output | W | Readback value |

## Verification
The bench builds the block with W=10, DEPTH=16 and two wipers. It shortens the busy windows to T_STORE=5, T_RECALL=3 and T_READ=2. With these short windows, every one of the sixteen addresses can be swept through the midscale default, a direct write, a protected write attempt and a readback within a short run. Each busy window can be counted to the exact cycle. The preset pin can be pulled low during a store window, which checks the held-recall ordering. The data pattern includes the code extremes 0 and 1023.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
   typedef enum logic [3:0] {
      OP_NOP        = 4'd0,
      OP_RECALL_ONE = 4'd1,
      OP_SAVE       = 4'd2,
      OP_WRITE      = 4'd3,
      OP_RECALL_ALL = 4'd8,
      OP_READ_NV    = 4'd9,
      OP_READ_WIPER = 4'd10
   } op_e;

   typedef enum logic {
      ST_IDLE,
      ST_BUSY
   } state_e;

   typedef enum logic [1:0] {
      JOB_STORE,
      JOB_RECALL,
      JOB_READ
   } job_e;
endpackage

// File: rtl/nvps_array.sv
module nvps_array #(
   parameter int W     = 10,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [W-1:0]       wdata,
   output logic [DEPTH*W-1:0] words_o
);
   localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         logic         prog_q;
         logic [W-1:0] cell_q;
         logic         hit;

         assign hit = we && (waddr == AW'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prog_q <= 1'b0;
            else if (hit) prog_q <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (hit) cell_q <= wdata;
         end

         assign words_o[i*W +: W] = prog_q ? cell_q : MIDSCALE;
      end
   endgenerate
endmodule

// File: rtl/nvps_pin_sync.sv
module nvps_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_o
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-1:0], pin_n};
   end

   assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
   parameter int CW = 8,
   parameter logic [CW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= RST_VAL;
      else if (load)                  cnt_q <= load_val;
      else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = run && (cnt_q == '0);
endmodule

// File: rtl/nv_preset_seq.sv
module nv_preset_seq
   import nvps_pkg::*;
#(
   parameter int W           = 10,
   parameter int DEPTH       = 16,
   parameter int NUM_WIPER   = 2,
   parameter int T_STORE     = 200000,
   parameter int T_RECALL    = 10000,
   parameter int T_READ      = 1000,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int LW         = NUM_WIPER * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [3:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [W-1:0]  cmd_data,
   input  logic [LW-1:0] wiper_cur_i,
   input  logic          preset_n,
   input  logic          wp_n,
   output logic          ready_o,
   output logic          drop_o,
   output logic [NUM_WIPER-1:0] wiper_we_o,
   output logic [LW-1:0] wiper_data_o,
   output logic          rd_valid_o,
   output logic [W-1:0]  rd_data_o
);
   localparam int TMAX = (T_STORE > T_RECALL) ?
                         ((T_STORE > T_READ) ? T_STORE : T_READ) :
                         ((T_RECALL > T_READ) ? T_RECALL : T_READ);
   localparam int CW = $clog2(TMAX) + 1;
   localparam logic [AW-1:0] NW_A = AW'(NUM_WIPER);

   generate
      if (W < 2) begin : g_bad_width
         $error("W must be at least 2");
      end
      if (NUM_WIPER < 1 || NUM_WIPER >= DEPTH) begin : g_bad_lanes
         $error("NUM_WIPER must be between 1 and DEPTH-1");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (T_STORE < 1 || T_RECALL < 1 || T_READ < 1) begin : g_bad_time
         $error("busy windows must be at least one cycle");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   state_e        st_q;
   job_e          job_q;
   logic [AW-1:0] addr_q;
   logic [W-1:0]  data_q;
   logic          pend_q;
   logic          drop_q;
   logic          rdv_q;
   logic [W-1:0]  rdd_q;

   logic          idle, pre_fall, rec_go, done;
   logic          start_store, start_rec, start_read, do_rec1, drop;
   logic          is_wip;
   logic [W-1:0]  wip_sel, nv_sel;
   logic [CW-1:0] ld_val;
   logic [DEPTH*W-1:0] nv_words;

   nvps_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (preset_n),
      .fall_o (pre_fall)
   );

   nvps_array #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (done && job_q == JOB_STORE),
      .waddr   (addr_q),
      .wdata   (data_q),
      .words_o (nv_words)
   );

   nvps_timer #(.CW(CW), .RST_VAL(CW'(T_RECALL - 1))) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_store | start_rec | start_read),
      .load_val (ld_val),
      .run      (st_q == ST_BUSY),
      .done     (done)
   );

   assign idle   = (st_q == ST_IDLE);
   assign rec_go = pend_q | pre_fall;
   assign is_wip = (cmd_addr < NW_A);

   always_comb begin
      wip_sel = '0;
      nv_sel  = '0;
      for (int i = 0; i < NUM_WIPER; i++)
         if (cmd_addr == AW'(i)) wip_sel = wiper_cur_i[i*W +: W];
      for (int j = 0; j < DEPTH; j++)
         if (cmd_addr == AW'(j)) nv_sel = nv_words[j*W +: W];
   end

   always_comb begin
      start_store = 1'b0;
      start_rec   = 1'b0;
      start_read  = 1'b0;
      do_rec1     = 1'b0;
      drop        = 1'b0;
      if (!idle) begin
         drop = cmd_valid;
      end else if (rec_go) begin
         start_rec = 1'b1;
         drop      = cmd_valid;
      end else if (cmd_valid) begin
         case (cmd_op)
            OP_RECALL_ONE: do_rec1     = is_wip;
            OP_SAVE:       start_store = is_wip && wp_n;
            OP_WRITE:      start_store = wp_n;
            OP_RECALL_ALL: start_rec   = 1'b1;
            OP_READ_NV:    start_read  = 1'b1;
            OP_READ_WIPER: start_read  = is_wip;
            default:       ;
         endcase
      end
   end

   always_comb begin
      if (start_store)     ld_val = CW'(T_STORE - 1);
      else if (start_read) ld_val = CW'(T_READ - 1);
      else                 ld_val = CW'(T_RECALL - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BUSY;
         job_q  <= JOB_RECALL;
         addr_q <= '0;
         data_q <= '0;
         pend_q <= 1'b0;
         drop_q <= 1'b0;
         rdv_q  <= 1'b0;
         rdd_q  <= '0;
      end else begin
         drop_q <= drop;
         rdv_q  <= 1'b0;
         pend_q <= start_rec ? 1'b0 : (pend_q | pre_fall);
         if (start_store | start_rec | start_read) begin
            st_q   <= ST_BUSY;
            addr_q <= cmd_addr;
            if (start_rec)        job_q <= JOB_RECALL;
            else if (start_store) job_q <= JOB_STORE;
            else                  job_q <= JOB_READ;
            if (start_store)
               data_q <= (cmd_op == OP_SAVE) ? wip_sel : cmd_data;
            else
               data_q <= (cmd_op == OP_READ_WIPER) ? wip_sel : nv_sel;
         end else if (done) begin
            st_q <= ST_IDLE;
            if (job_q == JOB_READ) begin
               rdv_q <= 1'b1;
               rdd_q <= data_q;
            end
         end
      end
   end

   generate
      for (genvar i = 0; i < NUM_WIPER; i++) begin : g_lane
         logic         we_q;
         logic [W-1:0] val_q;
         logic         hit;

         assign hit = (do_rec1 && cmd_addr == AW'(i)) || (done && job_q == JOB_RECALL);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               we_q  <= 1'b0;
               val_q <= '0;
            end else begin
               we_q <= hit;
               if (hit) val_q <= nv_words[i*W +: W];
            end
         end

         assign wiper_we_o[i]         = we_q;
         assign wiper_data_o[i*W +: W] = val_q;
      end
   endgenerate

   assign ready_o    = idle;
   assign drop_o     = drop_q;
   assign rd_valid_o = rdv_q;
   assign rd_data_o  = rdd_q;
endmodule

// File: rtl/nvps_chk.sv
module nvps_chk #(
   parameter int NUM_WIPER = 2,
   parameter int AW        = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic [3:0]           cmd_op,
   input logic [AW-1:0]        cmd_addr,
   input logic                 wp_n,
   input logic                 ready_o,
   input logic                 drop_o,
   input logic                 rd_valid_o,
   input logic [NUM_WIPER-1:0] wiper_we_o,
   input logic                 rec_go
);
   localparam logic [AW-1:0] NW_A = AW'(NUM_WIPER);

   logic take;
   assign take = ready_o && cmd_valid && !rec_go;

   assert_store_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wp_n && cmd_op == 4'd3) |=> !ready_o);

   assert_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wp_n && (cmd_op == 4'd2 || cmd_op == 4'd3)) |=> ready_o);

   assert_all_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(wiper_we_o) > 1) |-> (ready_o && $past(!ready_o)));

   assert_read_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> (ready_o && $past(!ready_o)));

   assert_recall_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 4'd1 && cmd_addr < NW_A) |=> (ready_o && $countones(wiper_we_o) == 1));

   assert_preset_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && rec_go) |=> !ready_o);

   assert_drop_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && cmd_valid) |=> drop_o);

   assert_idle_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(cmd_op inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10}))
      |=> (ready_o && wiper_we_o == '0 && !rd_valid_o));
endmodule

bind nv_preset_seq nvps_chk #(.NUM_WIPER(NUM_WIPER), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_addr   (cmd_addr),
   .wp_n       (wp_n),
   .ready_o    (ready_o),
   .drop_o     (drop_o),
   .rd_valid_o (rd_valid_o),
   .wiper_we_o (wiper_we_o),
   .rec_go     (rec_go)
);

// File: tb/nv_preset_seq_tb.sv
`timescale 1ns/1ps
module nv_preset_seq_tb;
   localparam int W = 10, DEPTH = 16, NW = 2;
   localparam int TS = 5, TR = 3, TD = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_op = '0;
   logic [3:0]    cmd_addr = '0;
   logic [W-1:0]  cmd_data = '0;
   logic [NW*W-1:0] wiper_cur = '0;
   logic          preset_n = 1'b1;
   logic          wp_n = 1'b1;
   logic          ready_o, drop_o, rd_valid_o;
   logic [NW-1:0] wiper_we_o;
   logic [NW*W-1:0] wiper_data_o;
   logic [W-1:0]  rd_data_o;

   nv_preset_seq #(.W(W), .DEPTH(DEPTH), .NUM_WIPER(NW), .T_STORE(TS),
                   .T_RECALL(TR), .T_READ(TD), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wiper_cur_i(wiper_cur),
      .preset_n(preset_n), .wp_n(wp_n), .ready_o(ready_o), .drop_o(drop_o),
      .wiper_we_o(wiper_we_o), .wiper_data_o(wiper_data_o),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
   );

   int n_chk = 0, n_fail = 0;
   int busy_n;
   logic [NW-1:0]   cap_we;
   logic [NW*W-1:0] cap_wd;
   logic            cap_rv;
   logic [W-1:0]    cap_rd;
   logic [W-1:0]    nv [DEPTH];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic grab();
      cap_we = wiper_we_o; cap_wd = wiper_data_o; cap_rv = rd_valid_o; cap_rd = rd_data_o;
   endtask

   task automatic follow();
      busy_n = 0;
      grab();
      while (!ready_o && busy_n < 500) begin
         @(negedge clk); busy_n++; grab();
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [3:0] a, input logic [W-1:0] d,
                        input bit preset_mid);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (preset_mid) preset_n = 1'b0;
      busy_n = 0;
      grab();
      while (!ready_o && busy_n < 500) begin
         @(negedge clk); busy_n++; grab();
         if (preset_mid && busy_n == 3) preset_n = 1'b1;
      end
   endtask

   function automatic logic [W-1:0] pat(input int a);
      if (a == 0) return '0;
      if (a == DEPTH - 1) return '1;
      return W'((a * 73 + 11) % 1024);
   endfunction

   task automatic read_all(input string tag);
      for (int a = 0; a < DEPTH; a++) begin
         issue(4'd9, 4'(a), '0, 1'b0);
         chk({tag, " busy"}, busy_n, TD);
         chk({tag, " valid"}, cap_rv, 1);
         chk({tag, " data"}, cap_rd, nv[a]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) nv[a] = 10'd512;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", ready_o, 0);
      chk("R1 no load in reset", wiper_we_o, 0);
      chk("R11 no drop in reset", drop_o, 0);
      rst_n = 1'b1;
      follow();
      chk("R1 power-up busy", busy_n, TR);
      chk("R1 power-up load", cap_we, 2'b11);
      chk("R1 lane0 midscale", cap_wd[0 +: W], 512);
      chk("R1 lane1 midscale", cap_wd[W +: W], 512);

      read_all("R2 R7 default");

      for (int a = 0; a < DEPTH; a++) begin
         issue(4'd3, 4'(a), pat(a), 1'b0);
         chk("R4 write busy", busy_n, TS);
         nv[a] = pat(a);
      end
      read_all("R4 R7 written");

      wp_n = 1'b0;
      for (int a = 0; a < DEPTH; a++) begin
         issue(4'd3, 4'(a), ~pat(a), 1'b0);
         chk("R5 protected write ready", busy_n, 0);
      end
      wiper_cur = {10'd77, 10'd901};
      issue(4'd2, 4'd0, '0, 1'b0);
      chk("R5 protected save ready", busy_n, 0);
      wp_n = 1'b1;
      read_all("R5 unchanged");

      wiper_cur = {10'h155, 10'h2AA};
      issue(4'd2, 4'd0, '0, 1'b0);
      chk("R3 save0 busy", busy_n, TS);
      nv[0] = 10'h2AA;
      issue(4'd2, 4'd1, '0, 1'b0);
      chk("R3 save1 busy", busy_n, TS);
      nv[1] = 10'h155;
      issue(4'd2, 4'd5, '0, 1'b0);
      chk("R3 save spare ignored", busy_n, 0);
      issue(4'd9, 4'd0, '0, 1'b0); chk("R3 save0 data", cap_rd, nv[0]);
      issue(4'd9, 4'd1, '0, 1'b0); chk("R3 save1 data", cap_rd, nv[1]);
      issue(4'd9, 4'd5, '0, 1'b0); chk("R3 spare kept", cap_rd, nv[5]);

      issue(4'd1, 4'd1, '0, 1'b0);
      chk("R9 single busy", busy_n, 0);
      chk("R9 single strobe", cap_we, 2'b10);
      chk("R9 single data", cap_wd[W +: W], nv[1]);
      issue(4'd1, 4'd0, '0, 1'b0);
      chk("R9 single strobe0", cap_we, 2'b01);
      chk("R9 single data0", cap_wd[0 +: W], nv[0]);

      issue(4'd3, 4'd0, 10'd3, 1'b0); nv[0] = 10'd3;
      issue(4'd8, 4'd0, '0, 1'b0);
      chk("R6 recall busy", busy_n, TR);
      chk("R6 recall strobe", cap_we, 2'b11);
      chk("R6 lane0", cap_wd[0 +: W], nv[0]);
      chk("R6 lane1", cap_wd[W +: W], nv[1]);

      wiper_cur = {10'd7, 10'd1000};
      issue(4'd10, 4'd0, '0, 1'b0);
      chk("R8 wiper0 busy", busy_n, TD);
      chk("R8 wiper0 data", cap_rd, 1000);
      issue(4'd10, 4'd1, '0, 1'b0);
      chk("R8 wiper1 data", cap_rd, 7);

      issue(4'd3, 4'd1, 10'd640, 1'b0); nv[1] = 10'd640;
      @(negedge clk); preset_n = 1'b0;
      @(negedge clk); chk("R10 sync stage 1", ready_o, 1);
      @(negedge clk); chk("R10 sync stage 2", ready_o, 1);
      @(negedge clk); chk("R10 preset start", ready_o, 0);
      preset_n = 1'b1;
      follow();
      chk("R10 preset busy", busy_n, TR);
      chk("R10 preset strobe", cap_we, 2'b11);
      chk("R10 preset lane1", cap_wd[W +: W], 640);

      issue(4'd3, 4'd7, 10'd55, 1'b1); nv[7] = 10'd55;
      chk("R10 store ends first", busy_n, TS);
      @(negedge clk);
      chk("R10 held recall start", ready_o, 0);
      follow();
      chk("R10 held recall busy", busy_n, TR);
      chk("R10 held recall strobe", cap_we, 2'b11);

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'd9; cmd_addr = 4'd2;
      @(negedge clk);
      cmd_op = 4'd3; cmd_addr = 4'd4; cmd_data = 10'd99;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 drop flag", drop_o, 1);
      follow();
      issue(4'd9, 4'd4, '0, 1'b0);
      chk("R11 ignored write", cap_rd, nv[4]);

      for (int op = 0; op < 16; op++) begin
         if (op inside {1, 2, 3, 8, 9, 10}) continue;
         issue(4'(op), 4'd0, 10'd1, 1'b0);
         chk("R12 ready kept", busy_n, 0);
         chk("R12 no strobe", cap_we, 0);
         chk("R12 no readback", cap_rv, 0);
      end
      issue(4'd9, 4'd0, '0, 1'b0);
      chk("R12 word kept", cap_rd, nv[0]);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule